// File: doc/BRIEF.md
# Timer Interrupt Dispatcher with Message Delivery

This block sits between a bank of event-timer channels and the interrupt fabric. Each channel can raise a fire request or a clear request. Depending on the channel's configuration word, a fire becomes one of three things. It can be a level-held interrupt line, a one-clock edge pulse on a line, or a 32-bit memory-write message. The message's address and data come from that channel's 64-bit route value. A status register holds one bit per channel and records the level-type interrupts that are outstanding.

The comparator logic and the register bus decode are outside this block. They supply the global enable, each channel's configuration word and route value, and the fire and clear strobes. Software clears a status bit by writing one to it, which the register decode passes in as a per-channel strobe. Messages leave through a valid/ready write-request port. When messages are waiting, they go out one at a time, starting with the lowest channel.

Configuration word layout, per channel (16 bits):
- bit 1: level type (1 = level, 0 = edge).
- bit 2: channel enable.
- bits 13:9: output line index.
- bit 14: message delivery enable.

Top module: `timer_irq_dispatch`

## Requirements
- R1: After a synchronous active-low reset, `irq_status`, `irq_lines` and `msg_valid` are all zero.
- R2: In the cycle after any of these conditions is present, the channel's status bit (bit index = channel number) reads 0: a clear request, config bit 2 (enable) low, or `glb_en` low.
- R3: Take a channel with enable (bit 2) set, level type (bit 1) set and message enable (bit 14) clear. A fire sets its status bit and asserts `irq_lines[cfg[13:9]]` from the next cycle on, and both stay until the channel is cleared.
- R4: A clear of a channel whose message enable is off deasserts its routed line in the next cycle. A clear of a channel whose message enable is on leaves every line unchanged.
- R5: A fire on an enabled channel with message enable (bit 14) set issues exactly one write with `msg_data` = route[31:0] and `msg_addr` = route[63:32]. `msg_valid` first rises two clocks after the fire is sampled. No status bit is set and no line is asserted.
- R6: A fire on an enabled edge-type channel (bit 1 = 0) with message enable off drives its routed line high for exactly one clock, one cycle after the fire, and leaves its status bit 0.
- R7: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold their values.
- R8: Fires that arrive while messages are waiting are kept, one flag per channel, and are sent in ascending channel order. A repeated fire of a channel that is still waiting adds no extra message.
- R9: A software write-one-to-clear strobe for a channel clears its status bit and deasserts the line of a level-type channel in the next cycle.
- R10: When a channel's message enable bit goes from 0 to 1, the channel is cleared: its status bit and any level assertion drop in the next cycle.
- R11: A fire on a channel whose enable bit is 0, or while `glb_en` is 0, changes no status bit, no line and sends no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_en | input | 1 | Global enable for all channels |
| ch_cfg | input | NUM_CH*16 | Per-channel configuration words, channel c at [16c +: 16] |
| ch_route | input | NUM_CH*64 | Per-channel message route, channel c at [64c +: 64] |
| fire | input | NUM_CH | Per-channel fire request |
| clr | input | NUM_CH | Per-channel clear request |
| sts_w1c | input | NUM_CH | Per-channel software status clear strobe |
| irq_status | output | NUM_CH | Status bit per channel |
| irq_lines | output | NUM_LINES | Interrupt output lines |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Message write request accepted |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The bench builds the block with its defaults of three channels and 32 lines. With three channels, all waiting messages can be in flight at once, and their ascending delivery order can be checked. Three channels also let two channels share one line, so a message-mode clear can be shown to leave another channel's level assertion in place. With 32 lines, every value of the 5-bit route index is a real line, so the bench can steer channels to lines spread across the whole vector, including high indices.

// File: rtl/tid_pkg.sv
// Shared constants for the timer interrupt dispatcher: configuration
// word layout and widths. Assumes a 16-bit config word per channel.
package tid_pkg;
    localparam int CFG_W      = 16;
    localparam int CFG_LEVEL  = 1;
    localparam int CFG_EN     = 2;
    localparam int CFG_RT_LO  = 9;
    localparam int RT_W       = 5;
    localparam int CFG_MSG_EN = 14;
    localparam int ROUTE_W    = 64;
    localparam int MSG_W      = 32;
endpackage

// File: rtl/tid_chan_ctrl.sv
// Per-channel interrupt control: decides what a fire or clear does for
// one channel, holds its status bit and edge pulse, and raises a message
// request. Assumes clear-type conditions take priority over fire.
module tid_chan_ctrl
    import tid_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glb_en,
    input  logic [CFG_W-1:0] cfg,
    input  logic             fire,
    input  logic             clr,
    input  logic             w1c,
    output logic             sts_o,
    output logic             level_on_o,
    output logic             pulse_o,
    output logic             msg_req_o
);
    logic sts_q;
    logic pulse_q;
    logic msg_en_q;
    logic ch_on;
    logic msg_on;
    logic msg_rise;
    logic sts_kill;
    logic take;

    // Decode the channel's mode and the clear / accept conditions.
    always_comb begin
        ch_on    = cfg[CFG_EN] & glb_en;
        msg_on   = cfg[CFG_MSG_EN];
        msg_rise = msg_on & ~msg_en_q;
        sts_kill = clr | w1c | ~ch_on | msg_rise;
        take     = fire & ch_on & ~clr;
    end

    // Status bit, edge pulse and message-enable history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q    <= 1'b0;
            pulse_q  <= 1'b0;
            msg_en_q <= 1'b0;
        end else begin
            msg_en_q <= msg_on;
            pulse_q  <= take & ~msg_on & ~cfg[CFG_LEVEL];
            if (sts_kill) begin
                sts_q <= 1'b0;
            end else if (take & ~msg_on & cfg[CFG_LEVEL]) begin
                sts_q <= 1'b1;
            end
        end
    end

    assign sts_o      = sts_q;
    assign level_on_o = sts_q & cfg[CFG_LEVEL] & ~msg_on;
    assign pulse_o    = pulse_q;
    assign msg_req_o  = take & msg_on;

    // R2: any clear-type condition leaves the status bit low next cycle.
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr || !cfg[CFG_EN] || !glb_en) |=> !sts_o);

    // R9: software clear strobe drops the status bit.
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        w1c |=> !sts_o);

    // R10: a rising message enable clears the channel.
    p_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_rise |=> !sts_o);

    // R5: a fire in message mode never sets the status bit.
    p_msg_nosts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && msg_on && !sts_o) |=> !sts_o);
endmodule

// File: rtl/tid_line_map.sv
// Maps per-channel level assertions and edge pulses onto the output
// lines using each channel's 5-bit route index. Channels sharing a line
// are ORed. Assumes NUM_LINES <= 2**RT_W; higher indices drive nothing.
module tid_line_map
    import tid_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int NUM_LINES = 32
) (
    input  logic [NUM_CH-1:0]      level_on,
    input  logic [NUM_CH-1:0]      pulse,
    input  logic [NUM_CH*RT_W-1:0] route_idx,
    output logic [NUM_LINES-1:0]   lines
);
    // OR every active channel into the line its route index selects.
    always_comb begin
        lines = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            for (int l = 0; l < NUM_LINES; l++) begin
                if ((level_on[c] || pulse[c]) &&
                    (route_idx[c*RT_W +: RT_W] == RT_W'(l))) begin
                    lines[l] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tid_msg_arb.sv
// Message sender: keeps one waiting flag per channel, grants the lowest
// waiting channel whenever the output register is free, and presents
// route[63:32] as address and route[31:0] as data on a valid/ready port.
module tid_msg_arb
    import tid_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         req,
    input  logic [NUM_CH*ROUTE_W-1:0] route,
    input  logic                      ready,
    output logic                      valid,
    output logic [MSG_W-1:0]          addr,
    output logic [MSG_W-1:0]          data
);
    logic [NUM_CH-1:0]  pend_q;
    logic [NUM_CH-1:0]  grant;
    logic [ROUTE_W-1:0] sel_route;
    logic               valid_q;
    logic [MSG_W-1:0]   addr_q;
    logic [MSG_W-1:0]   data_q;
    logic               free;

    // Pick the lowest waiting channel when the output slot is free.
    always_comb begin
        free      = ~valid_q | ready;
        grant     = '0;
        sel_route = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (free && pend_q[i] && (grant == '0)) begin
                grant[i]  = 1'b1;
                sel_route = route[i*ROUTE_W +: ROUTE_W];
            end
        end
    end

    // Waiting flags and the output message register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            valid_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            pend_q <= (pend_q & ~grant) | req;
            if (free) begin
                valid_q <= |grant;
                if (|grant) begin
                    addr_q <= sel_route[ROUTE_W-1:MSG_W];
                    data_q <= sel_route[MSG_W-1:0];
                end
            end
        end
    end

    assign valid = valid_q;
    assign addr  = addr_q;
    assign data  = data_q;

    // R7: a stalled request keeps its contents.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(addr) && $stable(data)));

    // R8: at most one channel is granted per cycle.
    p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
endmodule

// File: rtl/timer_irq_dispatch.sv
// Top of the timer interrupt dispatcher. Instantiates one control slice
// per channel, the line map and the message sender. Assumes config and
// route inputs come from a register file and are stable around fires.
module timer_irq_dispatch
    import tid_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int NUM_LINES = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      glb_en,
    input  logic [NUM_CH*CFG_W-1:0]   ch_cfg,
    input  logic [NUM_CH*ROUTE_W-1:0] ch_route,
    input  logic [NUM_CH-1:0]         fire,
    input  logic [NUM_CH-1:0]         clr,
    input  logic [NUM_CH-1:0]         sts_w1c,
    output logic [NUM_CH-1:0]         irq_status,
    output logic [NUM_LINES-1:0]      irq_lines,
    output logic                      msg_valid,
    input  logic                      msg_ready,
    output logic [MSG_W-1:0]          msg_addr,
    output logic [MSG_W-1:0]          msg_data
);
    logic [NUM_CH-1:0]      level_on;
    logic [NUM_CH-1:0]      pulse;
    logic [NUM_CH-1:0]      msg_req;
    logic [NUM_CH*RT_W-1:0] route_idx;

    // One control slice per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tid_chan_ctrl u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .glb_en     (glb_en),
            .cfg        (ch_cfg[c*CFG_W +: CFG_W]),
            .fire       (fire[c]),
            .clr        (clr[c]),
            .w1c        (sts_w1c[c]),
            .sts_o      (irq_status[c]),
            .level_on_o (level_on[c]),
            .pulse_o    (pulse[c]),
            .msg_req_o  (msg_req[c])
        );
        assign route_idx[c*RT_W +: RT_W] = ch_cfg[c*CFG_W + CFG_RT_LO +: RT_W];
    end

    tid_line_map #(
        .NUM_CH    (NUM_CH),
        .NUM_LINES (NUM_LINES)
    ) u_map (
        .level_on  (level_on),
        .pulse     (pulse),
        .route_idx (route_idx),
        .lines     (irq_lines)
    );

    tid_msg_arb #(
        .NUM_CH (NUM_CH)
    ) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (msg_req),
        .route (ch_route),
        .ready (msg_ready),
        .valid (msg_valid),
        .addr  (msg_addr),
        .data  (msg_data)
    );

    // R1: nothing is signalled in the cycle after reset.
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_status == '0 && !msg_valid));
endmodule

// File: tb/timer_irq_dispatch_tb.sv
`timescale 1ns/1ps
module timer_irq_dispatch_tb;
    localparam int NC = 3;
    localparam int NL = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            glb_en;
    logic [NC*16-1:0] ch_cfg;
    logic [NC*64-1:0] ch_route;
    logic [NC-1:0]   fire, clr, sts_w1c;
    logic [NC-1:0]   irq_status;
    logic [NL-1:0]   irq_lines;
    logic            msg_valid, msg_ready;
    logic [31:0]     msg_addr, msg_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    timer_irq_dispatch #(.NUM_CH(NC), .NUM_LINES(NL)) u_dut (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .ch_cfg(ch_cfg),
        .ch_route(ch_route), .fire(fire), .clr(clr), .sts_w1c(sts_w1c),
        .irq_status(irq_status), .irq_lines(irq_lines),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    function automatic logic [15:0] mk_cfg(bit lvl, bit en, int line, bit msg);
        logic [15:0] v = '0;
        v[1] = lvl; v[2] = en; v[13:9] = line[4:0]; v[14] = msg;
        return v;
    endfunction

    function automatic logic [31:0] exp_addr(int c);
        return 32'hA000_0000 + 32'(c * 16);
    endfunction
    function automatic logic [31:0] exp_data(int c);
        return 32'hD000_0000 + 32'(c);
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_in(ref logic [NC-1:0] sig, input logic [NC-1:0] v);
        sig = v;
        @(negedge clk);
        sig = '0;
    endtask

    task automatic quiet();
        fire = '0; clr = '0; sts_w1c = '0; msg_ready = 1'b0;
        ch_cfg = '0; glb_en = 1'b1;
        step(2);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; glb_en = 1'b0; ch_cfg = '0;
        fire = '0; clr = '0; sts_w1c = '0; msg_ready = 1'b0;
        for (int c = 0; c < NC; c++)
            ch_route[c*64 +: 64] = {exp_addr(c), exp_data(c)};
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq_status == '0, "R1 status", 64'(irq_status), 0);
        chk(irq_lines == '0, "R1 lines", 64'(irq_lines), 0);
        chk(msg_valid == 1'b0, "R1 valid", 64'(msg_valid), 0);
    endtask

    task automatic t_level();
        quiet();
        ch_cfg[16 +: 16] = mk_cfg(1, 1, 7, 0);
        pulse_in(fire, 3'b010);
        chk(irq_status == 3'b010, "R3 status set", 64'(irq_status), 2);
        chk(irq_lines == 32'h80, "R3 line 7", 64'(irq_lines), 64'h80);
        step(2);
        chk(irq_lines == 32'h80, "R3 line held", 64'(irq_lines), 64'h80);
        pulse_in(clr, 3'b010);
        chk(irq_status == 3'b000, "R2 clear", 64'(irq_status), 0);
        chk(irq_lines == '0, "R4 line dropped", 64'(irq_lines), 0);
    endtask

    task automatic t_edge();
        quiet();
        ch_cfg[0 +: 16] = mk_cfg(0, 1, 20, 0);
        pulse_in(fire, 3'b001);
        chk(irq_lines == 32'h0010_0000, "R6 pulse", 64'(irq_lines), 64'h10_0000);
        chk(irq_status == '0, "R6 no status", 64'(irq_status), 0);
        @(negedge clk);
        chk(irq_lines == '0, "R6 one clock", 64'(irq_lines), 0);
    endtask

    task automatic t_disabled();
        quiet();
        ch_cfg[32 +: 16] = mk_cfg(1, 0, 3, 0);
        pulse_in(fire, 3'b100);
        chk(irq_status == '0 && irq_lines == '0, "R11 channel off",
            64'(irq_lines), 0);
        ch_cfg[32 +: 16] = mk_cfg(1, 1, 3, 0);
        glb_en = 1'b0;
        pulse_in(fire, 3'b100);
        step(2);
        chk(irq_status == '0 && irq_lines == '0 && !msg_valid,
            "R11 global off", 64'(irq_status), 0);
        glb_en = 1'b1;
        pulse_in(fire, 3'b100);
        chk(irq_status == 3'b100, "R3 status ch2", 64'(irq_status), 4);
        glb_en = 1'b0;
        @(negedge clk);
        chk(irq_status == '0, "R2 global clear", 64'(irq_status), 0);
    endtask

    task automatic t_w1c();
        quiet();
        ch_cfg[16 +: 16] = mk_cfg(1, 1, 31, 0);
        pulse_in(fire, 3'b010);
        chk(irq_lines == 32'h8000_0000, "R3 line 31", 64'(irq_lines),
            64'h8000_0000);
        pulse_in(sts_w1c, 3'b010);
        chk(irq_status == '0 && irq_lines == '0, "R9 w1c",
            64'(irq_lines), 0);
    endtask

    task automatic t_msg_single();
        quiet();
        ch_cfg[32 +: 16] = mk_cfg(1, 1, 5, 1);
        step(1);
        pulse_in(fire, 3'b100);
        chk(msg_valid == 1'b0, "R5 not yet", 64'(msg_valid), 0);
        @(negedge clk);
        chk(msg_valid && msg_addr == exp_addr(2) && msg_data == exp_data(2),
            "R5 message", {msg_addr, msg_data}, {exp_addr(2), exp_data(2)});
        chk(irq_status == '0 && irq_lines == '0, "R5 no line",
            64'(irq_lines), 0);
        step(3);
        chk(msg_valid && msg_addr == exp_addr(2) && msg_data == exp_data(2),
            "R7 held", {msg_addr, msg_data}, {exp_addr(2), exp_data(2)});
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
        step(2);
        chk(msg_valid == 1'b0, "R5 single write", 64'(msg_valid), 0);
    endtask

    task automatic t_msg_clear_noline();
        quiet();
        ch_cfg[0 +: 16]  = mk_cfg(1, 1, 9, 0);
        ch_cfg[32 +: 16] = mk_cfg(1, 1, 9, 1);
        step(1);
        pulse_in(fire, 3'b001);
        pulse_in(clr, 3'b100);
        chk(irq_lines == 32'h200, "R4 message clear keeps line",
            64'(irq_lines), 64'h200);
        pulse_in(clr, 3'b001);
        chk(irq_lines == '0, "R4 plain clear", 64'(irq_lines), 0);
    endtask

    task automatic t_msg_order();
        int got;
        quiet();
        for (int c = 0; c < NC; c++) ch_cfg[c*16 +: 16] = mk_cfg(0, 1, c, 1);
        step(1);
        pulse_in(fire, 3'b111);
        step(2);
        pulse_in(fire, 3'b100);
        step(1);
        msg_ready = 1'b1;
        got = 0;
        for (int k = 0; k < 8; k++) begin
            if (msg_valid) begin
                if (got < NC)
                    chk(msg_data == exp_data(got) && msg_addr == exp_addr(got),
                        "R8 order", 64'(msg_data), 64'(exp_data(got)));
                got++;
            end
            @(negedge clk);
        end
        msg_ready = 1'b0;
        chk(got == NC, "R8 count", 64'(got), 64'(NC));
    endtask

    task automatic t_msg_rise();
        quiet();
        ch_cfg[16 +: 16] = mk_cfg(1, 1, 11, 0);
        pulse_in(fire, 3'b010);
        chk(irq_status == 3'b010, "R3 pre", 64'(irq_status), 2);
        ch_cfg[16 +: 16] = mk_cfg(1, 1, 11, 1);
        @(negedge clk);
        chk(irq_status == '0 && irq_lines == '0, "R10 cleared on enable",
            64'(irq_lines), 0);
        step(2);
        chk(msg_valid == 1'b0, "R10 no message", 64'(msg_valid), 0);
    endtask

    initial begin
        t_reset();
        t_level();
        t_edge();
        t_disabled();
        t_w1c();
        t_msg_single();
        t_msg_clear_noline();
        t_msg_order();
        t_msg_rise();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule